// File: doc/BRIEF.md
# Snooping Cache-Line Coherence Controller

This block keeps the coherence state of a handful of line frames in one private cache attached to a shared snooping bus. The core side presents one request at a time: load, store or evict, aimed at a frame. The controller decides whether the request can finish locally or needs a bus transaction. If it needs the bus, it raises a bus request with the right command and waits for the grant and, for reads, for the fill data. Each frame stores a single data word beside its state.

At the same time the controller watches transactions issued by other caches. When one of those names a frame it holds, it changes that frame's state. It supplies the line when it owns a dirty copy and reports on a shared-line output that it holds a copy. A parameter adds the Exclusive state. A read fill lands in Exclusive instead of Shared when the shared-line input, sampled with the fill, is low.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every frame is Invalid. `req_ready`, `bus_req`, `snp_reply` and `snp_shared` are low while no request or snoop is presented. Encodings: request op load=0, store=1, evict=2; bus/snoop command read=1, read-for-ownership=2, invalidate=3, write-back=4, reply=5.
- R2: A load to an Invalid frame raises `bus_req` with command 1. Once granted, it waits for `fill_valid`. In the fill cycle `req_ready` is high and `req_rdata` equals `fill_data`. The frame becomes Exclusive if `EXCL_EN` is set and `fill_shared` is low, otherwise Shared.
- R3: A store to an Invalid frame raises `bus_req` with command 2. It completes in the fill cycle, and the frame becomes Modified holding `req_wdata`.
- R4: A store to a Shared frame raises `bus_req` with command 3. It completes in the grant cycle, and the frame becomes Modified with the new word. A store to an Exclusive frame completes in the same cycle with no bus request and makes the frame Modified.
- R5: A load to a Shared, Exclusive or Modified frame, and a store to a Modified frame, complete in the cycle presented with no bus request. A load returns the frame's word.
- R6: Evicting a Modified frame raises `bus_req` with command 4 and `bus_wdata` equal to the frame's word. It completes in the grant cycle and leaves the frame Invalid. Evicting a Shared, Exclusive or Invalid frame completes at once with no bus request and leaves it Invalid.
- R7: A snooped read (1) on a Modified frame raises `snp_reply` with the frame's word on `snp_data` in the same cycle and leaves the frame Shared. On an Exclusive frame it leaves the frame Shared. `snp_shared` is high for a snooped read on any non-Invalid frame.
- R8: A snooped read-for-ownership (2) invalidates the frame and, if the frame was Modified, raises `snp_reply` with its word. A snooped invalidate (3) invalidates any valid frame. Snooped write-back (4) and reply (5) leave the state unchanged.
- R9: A request that needs the bus keeps `req_ready` low until the grant, and for commands 1 and 2 until the fill. If a snoop changes the frame's state while the grant is pending, the next request carries the command for the new state.
- R10: In a cycle where a snoop names the same frame as a request waiting to start, the request neither completes nor raises `bus_req`. The snoop is applied, and requests to other frames proceed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Local request present, held until `req_ready` |
| req_op | input | 2 | Request kind: 0 load, 1 store, 2 evict |
| req_frame | input | FW | Target frame index |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Request completes this cycle |
| req_rdata | output | DATA_W | Load result, zero when not completing a load |
| bus_req | output | 1 | Request for the shared bus |
| bus_cmd | output | 3 | Command issued with `bus_req` |
| bus_frame | output | FW | Frame the command concerns |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Bus granted; the command goes out this cycle |
| fill_valid | input | 1 | Fill data for the outstanding read arrives |
| fill_data | input | DATA_W | Fill word |
| fill_shared | input | 1 | Another cache holds the line, sampled with the fill |
| snp_valid | input | 1 | A transaction from another cache is on the bus |
| snp_cmd | input | 3 | Snooped command |
| snp_frame | input | FW | Frame the snooped command names |
| snp_reply | output | 1 | This cache supplies the line |
| snp_data | output | DATA_W | Supplied word |
| snp_shared | output | 1 | This cache holds a valid copy |

## Verification
The hardest case is an upgrade that loses its line before it wins the bus. A store to a Shared frame must be waiting with the grant withheld when a read-for-ownership from another cache arrives. The stimulus first fills a frame as Shared by returning a fill with the shared-line input high. It then holds the grant low for two cycles while the store waits, injects the read-for-ownership in the second cycle, and checks that the following cycle requests command 2 rather than 3. Random traffic afterwards mixes snoops and requests on the same frames, so snoop priority and mid-wait state changes recur many times.

// File: rtl/coh_pkg.sv
// Shared types for the line coherence controller.
// Assumes: encodings below are visible at the block's ports and fixed.
package coh_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2,
        LN_MOD = 2'd3
    } line_st_t;

    typedef enum logic [2:0] {
        BC_NONE  = 3'd0,
        BC_RD    = 3'd1,
        BC_RDX   = 3'd2,
        BC_INV   = 3'd3,
        BC_WB    = 3'd4,
        BC_REPLY = 3'd5
    } bcmd_t;

    localparam logic [1:0] OP_LOAD  = 2'd0;
    localparam logic [1:0] OP_STORE = 2'd1;
    localparam logic [1:0] OP_EVICT = 2'd2;
endpackage

// File: rtl/coh_local_dec.sv
// Decides how a core-side request is served, given the frame's current state.
// Assumes: op is one of load/store/evict; any other value is handled as evict.
module coh_local_dec
    import coh_pkg::*;
(
    input  line_st_t   st,
    input  logic [1:0] op,
    output logic       hit,
    output logic       need_bus,
    output bcmd_t      cmd,
    output line_st_t   hit_next,
    output logic       hit_write
);
    // Classify the request as local completion or bus transaction.
    always_comb begin
        hit       = 1'b0;
        need_bus  = 1'b0;
        cmd       = BC_NONE;
        hit_next  = st;
        hit_write = 1'b0;
        unique case (op)
            OP_LOAD: begin
                if (st == LN_INV) begin
                    need_bus = 1'b1;
                    cmd      = BC_RD;
                end else begin
                    hit = 1'b1;
                end
            end
            OP_STORE: begin
                if (st == LN_INV) begin
                    need_bus = 1'b1;
                    cmd      = BC_RDX;
                end else if (st == LN_SHR) begin
                    need_bus = 1'b1;
                    cmd      = BC_INV;
                end else begin
                    hit       = 1'b1;
                    hit_next  = LN_MOD;
                    hit_write = 1'b1;
                end
            end
            default: begin
                if (st == LN_MOD) begin
                    need_bus = 1'b1;
                    cmd      = BC_WB;
                end else begin
                    hit      = 1'b1;
                    hit_next = LN_INV;
                end
            end
        endcase
    end
endmodule

// File: rtl/coh_snoop_dec.sv
// Reaction of one frame to a transaction seen from another cache.
// Assumes: write-back and reply commands never change this cache's state.
module coh_snoop_dec
    import coh_pkg::*;
(
    input  logic     active,
    input  bcmd_t    cmd,
    input  line_st_t st,
    output line_st_t nxt,
    output logic     chg,
    output logic     reply,
    output logic     shared
);
    // Next state and responses for the snooped command.
    always_comb begin
        nxt    = st;
        reply  = 1'b0;
        shared = 1'b0;
        if (active) begin
            case (cmd)
                BC_RD: begin
                    shared = (st != LN_INV);
                    reply  = (st == LN_MOD);
                    if (st == LN_MOD || st == LN_EXC) nxt = LN_SHR;
                end
                BC_RDX: begin
                    reply = (st == LN_MOD);
                    nxt   = LN_INV;
                end
                BC_INV:  nxt = LN_INV;
                default: nxt = st;
            endcase
        end
        chg = active && (nxt != st);
    end
endmodule

// File: rtl/coh_line_ctrl.sv
// Per-frame coherence controller for one private cache on a snooping bus.
// Holds state and one data word per frame, serves one core request at a
// time, and reacts to snooped transactions with priority over that request.
// Assumes: req_* held stable until req_ready; FRAMES is a power of two >= 2.
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int FRAMES  = 4,
    parameter int DATA_W  = 8,
    parameter bit EXCL_EN = 1'b1,
    localparam int FW     = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [FW-1:0]     req_frame,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata,
    output logic              bus_req,
    output logic [2:0]        bus_cmd,
    output logic [FW-1:0]     bus_frame,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_shared,
    input  logic              snp_valid,
    input  logic [2:0]        snp_cmd,
    input  logic [FW-1:0]     snp_frame,
    output logic              snp_reply,
    output logic [DATA_W-1:0] snp_data,
    output logic              snp_shared
);
    line_st_t          state_q [FRAMES];
    logic [DATA_W-1:0] data_q  [FRAMES];
    logic              fill_phase_q;

    line_st_t cur_st, hit_next, snp_next, loc_next;
    bcmd_t    loc_cmd;
    logic     hit, need_bus, hit_write;
    logic     snp_chg, snp_rep, snp_shr;
    logic     same_frame, go, granted, done_hit, done_grant, done_fill;
    logic     loc_we, loc_dwe, is_load;
    logic [DATA_W-1:0] loc_wdata;

    assign cur_st  = state_q[req_frame];
    assign is_load = (req_op == OP_LOAD);

    coh_local_dec u_loc (
        .st(cur_st), .op(req_op), .hit(hit), .need_bus(need_bus),
        .cmd(loc_cmd), .hit_next(hit_next), .hit_write(hit_write)
    );

    coh_snoop_dec u_snp (
        .active(snp_valid), .cmd(bcmd_t'(snp_cmd)), .st(state_q[snp_frame]),
        .nxt(snp_next), .chg(snp_chg), .reply(snp_rep), .shared(snp_shr)
    );

    // Request progress: snoop on the same frame stalls a request not yet on the bus.
    always_comb begin
        same_frame = snp_valid && (snp_frame == req_frame);
        go         = req_valid && !fill_phase_q && !same_frame;
        granted    = go && need_bus && bus_gnt;
        done_hit   = go && hit;
        done_grant = granted && (loc_cmd == BC_INV || loc_cmd == BC_WB);
        done_fill  = fill_phase_q && req_valid && fill_valid;
        loc_we     = done_hit || done_grant || done_fill;
        loc_dwe    = (done_hit && hit_write) || (done_grant && loc_cmd == BC_INV) || done_fill;
        loc_wdata  = (done_fill && is_load) ? fill_data : req_wdata;
    end

    // Next state written by the local side.
    always_comb begin
        loc_next = hit_next;
        if (done_fill) begin
            if (!is_load)                      loc_next = LN_MOD;
            else if (EXCL_EN && !fill_shared)  loc_next = LN_EXC;
            else                               loc_next = LN_SHR;
        end else if (done_grant) begin
            loc_next = (loc_cmd == BC_INV) ? LN_MOD : LN_INV;
        end
    end

    // Port drive; data outputs are zero unless meaningful.
    always_comb begin
        req_ready  = loc_we;
        req_rdata  = '0;
        if (req_ready && is_load) req_rdata = done_fill ? fill_data : data_q[req_frame];
        bus_req    = go && need_bus;
        bus_cmd    = bus_req ? loc_cmd : BC_NONE;
        bus_frame  = bus_req ? req_frame : '0;
        bus_wdata  = (bus_req && loc_cmd == BC_WB) ? data_q[req_frame] : '0;
        snp_reply  = snp_rep;
        snp_data   = snp_rep ? data_q[snp_frame] : '0;
        snp_shared = snp_shr;
    end

    // Tracks whether a read-type transaction awaits its fill.
    always_ff @(posedge clk) begin
        if (!rst_n)                                                   fill_phase_q <= 1'b0;
        else if (granted && (loc_cmd == BC_RD || loc_cmd == BC_RDX))  fill_phase_q <= 1'b1;
        else if (done_fill)                                           fill_phase_q <= 1'b0;
    end

    for (genvar i = 0; i < FRAMES; i++) begin : g_frame
        // Frame state: a changing snoop wins over the local update.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    state_q[i] <= LN_INV;
            else if (snp_chg && snp_frame == FW'(i))       state_q[i] <= snp_next;
            else if (loc_we && req_frame == FW'(i))        state_q[i] <= loc_next;
        end
        // Frame data word, written by stores and fills.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    data_q[i] <= '0;
            else if (loc_dwe && req_frame == FW'(i))       data_q[i] <= loc_wdata;
        end
    end
endmodule

// File: rtl/coh_line_ctrl_chk.sv
// Port-level temporal checks for coh_line_ctrl, attached by bind.
// Assumes: same encodings as coh_pkg.
module coh_line_ctrl_chk #(
    parameter int FRAMES = 4,
    parameter int DATA_W = 8,
    localparam int FW    = $clog2(FRAMES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [FW-1:0] req_frame,
    input logic          req_ready,
    input logic          bus_req,
    input logic [2:0]    bus_cmd,
    input logic          bus_gnt,
    input logic          fill_valid,
    input logic          snp_valid,
    input logic [2:0]    snp_cmd,
    input logic [FW-1:0] snp_frame,
    input logic          snp_reply,
    input logic          snp_shared
);
    // R9
    wait_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |-> !req_ready);
    // R4
    upgrade_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt && bus_cmd == 3'd3 |-> req_ready);
    // R2
    read_waits_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt && bus_cmd == 3'd1 |=> !bus_req);
    // R7
    reply_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_reply && snp_cmd == 3'd1 |-> snp_shared);
    // R8
    reply_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_reply |-> snp_valid && (snp_cmd == 3'd1 || snp_cmd == 3'd2));
    // R10
    snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && req_valid && snp_frame == req_frame && !fill_valid |-> !req_ready && !bus_req);
    // R1
    cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_cmd >= 3'd1 && bus_cmd <= 3'd4);
endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.FRAMES(FRAMES), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_frame(req_frame),
    .req_ready(req_ready), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_gnt(bus_gnt),
    .fill_valid(fill_valid), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_frame(snp_frame), .snp_reply(snp_reply), .snp_shared(snp_shared)
);

// File: tb/coh_line_ctrl_test.sv
// Bench: behavioural reference model compared with every output on every clock.
module coh_line_ctrl_test;
    localparam int FRAMES = 4;
    localparam int DW     = 8;
    localparam int FW     = 2;
    localparam bit EXCL   = 1'b1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          req_valid = 0;
    logic [1:0]    req_op = 0;
    logic [FW-1:0] req_frame = 0;
    logic [DW-1:0] req_wdata = 0;
    logic          req_ready;
    logic [DW-1:0] req_rdata;
    logic          bus_req;
    logic [2:0]    bus_cmd;
    logic [FW-1:0] bus_frame;
    logic [DW-1:0] bus_wdata;
    logic          bus_gnt = 0, fill_valid = 0, fill_shared = 0, snp_valid = 0;
    logic [DW-1:0] fill_data = 0;
    logic [2:0]    snp_cmd = 0;
    logic [FW-1:0] snp_frame = 0;
    logic          snp_reply, snp_shared;
    logic [DW-1:0] snp_data;

    coh_line_ctrl #(.FRAMES(FRAMES), .DATA_W(DW), .EXCL_EN(EXCL)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_frame(req_frame), .req_wdata(req_wdata), .req_ready(req_ready),
        .req_rdata(req_rdata), .bus_req(bus_req), .bus_cmd(bus_cmd),
        .bus_frame(bus_frame), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
        .fill_valid(fill_valid), .fill_data(fill_data), .fill_shared(fill_shared),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_frame(snp_frame),
        .snp_reply(snp_reply), .snp_data(snp_data), .snp_shared(snp_shared)
    );

    int checks = 0, fails = 0;
    int ms [FRAMES];   // model state: 0 I, 1 S, 2 E, 3 M
    int md [FRAMES];
    int mph = 0;       // 1 while a fill is awaited
    bit last_ready = 0;
    bit finished = 0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: compare at the falling edge, advance the model, return after the rising edge.
    task automatic step();
        int e_rdy, e_rd, e_br, e_bc, e_bf, e_bw, e_rep, e_sd, e_sh;
        int sn_new, nls, nd, mph_n, cs, cmd, s;
        bit need;
        string lt, stg;
        @(negedge clk);
        e_rdy = 0; e_rd = 0; e_br = 0; e_bc = 0; e_bf = 0; e_bw = 0;
        e_rep = 0; e_sd = 0; e_sh = 0; sn_new = -1; nls = -1; nd = -1; mph_n = mph;
        lt = "R1"; stg = "R1";
        if (rst_n && snp_valid) begin
            s = ms[snp_frame];
            stg = (snp_cmd == 3'd1) ? "R7" : "R8";
            case (snp_cmd)
                3'd1: begin
                    if (s != 0) e_sh = 1;
                    if (s == 3) begin e_rep = 1; e_sd = md[snp_frame]; end
                    if (s >= 2) sn_new = 1;
                end
                3'd2: begin
                    if (s == 3) begin e_rep = 1; e_sd = md[snp_frame]; end
                    if (s != 0) sn_new = 0;
                end
                3'd3: if (s != 0) sn_new = 0;
                default: ;
            endcase
        end
        if (rst_n && req_valid) begin
            cs = ms[req_frame];
            if (mph == 0) begin
                if (snp_valid && snp_frame == req_frame) lt = "R10";
                else begin
                    need = 0; cmd = 0;
                    case (req_op)
                        2'd0: if (cs == 0) begin need = 1; cmd = 1; lt = "R2"; end
                              else begin lt = "R5"; e_rdy = 1; e_rd = md[req_frame]; end
                        2'd1: if (cs == 0) begin need = 1; cmd = 2; lt = "R3"; end
                              else if (cs == 1) begin need = 1; cmd = 3; lt = "R4"; end
                              else begin e_rdy = 1; lt = (cs == 2) ? "R4" : "R5"; nls = 3; nd = req_wdata; end
                        default: if (cs == 3) begin need = 1; cmd = 4; lt = "R6"; end
                                 else begin e_rdy = 1; lt = "R6"; nls = 0; end
                    endcase
                    if (need) begin
                        e_br = 1; e_bc = cmd; e_bf = req_frame;
                        if (cmd == 4) e_bw = md[req_frame];
                        if (!bus_gnt) lt = "R9";
                        else if (cmd == 3) begin e_rdy = 1; nls = 3; nd = req_wdata; end
                        else if (cmd == 4) begin e_rdy = 1; nls = 0; end
                        else mph_n = 1;
                    end
                end
            end else begin
                lt = (req_op == 2'd0) ? "R2" : "R3";
                if (!fill_valid) lt = "R9";
                else begin
                    e_rdy = 1; mph_n = 0;
                    if (req_op == 2'd0) begin
                        e_rd = fill_data; nd = fill_data;
                        nls = (EXCL && !fill_shared) ? 2 : 1;
                    end else begin
                        nls = 3; nd = req_wdata;
                    end
                end
            end
        end
        chk(lt, "req_ready", req_ready, e_rdy);
        chk(lt, "req_rdata", req_rdata, e_rd);
        chk(lt, "bus_req", bus_req, e_br);
        chk(lt, "bus_cmd", bus_cmd, e_bc);
        chk(lt, "bus_frame", bus_frame, e_bf);
        chk(lt, "bus_wdata", bus_wdata, e_bw);
        chk(stg, "snp_reply", snp_reply, e_rep);
        chk(stg, "snp_data", snp_data, e_sd);
        chk(stg, "snp_shared", snp_shared, e_sh);
        if (sn_new >= 0) ms[snp_frame] = sn_new;
        if (nls >= 0) ms[req_frame] = nls;
        if (nd >= 0) md[req_frame] = nd;
        mph = mph_n;
        last_ready = e_rdy[0];
        @(posedge clk);
        #1;
    endtask

    // Hold a request until it completes; grant after gdly cycles, fill one cycle after grant.
    task automatic do_req(input int op, input int f, input int wd, input int gdly, input bit shr);
        int cnt = 0;
        req_valid = 1; req_op = 2'(op); req_frame = FW'(f); req_wdata = DW'(wd);
        fill_shared = shr;
        do begin
            bus_gnt = (cnt >= gdly);
            fill_valid = (mph == 1);
            fill_data = DW'(8'hA0 + cnt + f);
            step();
            cnt++;
        end while (!last_ready && cnt < 60);
        req_valid = 0; bus_gnt = 0; fill_valid = 0;
    endtask

    task automatic snoop(input int cmd, input int f);
        snp_valid = 1; snp_cmd = 3'(cmd); snp_frame = FW'(f);
        step();
        snp_valid = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL R9 watchdog expired: actual 0 expected 1 completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < FRAMES; i++) begin ms[i] = 0; md[i] = 0; end
        rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
        // R1: idle outputs after reset
        chk("R1", "bus_req idle", bus_req, 0);
        chk("R1", "req_ready idle", req_ready, 0);
        // R1: first load misses, R2 fill without sharers gives Exclusive
        do_req(0, 0, 0, 1, 0);
        do_req(1, 0, 8'h5A, 0, 0);        // R4 Exclusive store silent
        do_req(0, 0, 0, 0, 0);            // R5 load hit returns 0x5A
        snoop(1, 0);                      // R7 owner supplies, drops to Shared
        do_req(0, 0, 0, 0, 0);            // R5 Shared load
        do_req(1, 0, 8'h11, 2, 0);        // R4 upgrade via invalidate
        do_req(0, 1, 0, 0, 1);            // R2 fill with sharers gives Shared
        // R9: upgrade on frame 1 loses the line while waiting for grant
        req_valid = 1; req_op = 2'd1; req_frame = 1; req_wdata = 8'h77; bus_gnt = 0;
        step();
        chk("R9", "upgrade cmd pending", bus_cmd, 3);
        snp_valid = 1; snp_cmd = 3'd2; snp_frame = 1;
        step();                           // R10 stall on same frame
        snp_valid = 0;
        step();
        chk("R9", "reissued cmd", bus_cmd, 2);
        bus_gnt = 1; step(); bus_gnt = 0;
        fill_valid = 1; fill_data = 8'h33; step(); fill_valid = 0;
        chk("R3", "store fill done", last_ready, 1);
        req_valid = 0;
        do_req(2, 1, 0, 1, 0);            // R6 write-back of 0x77
        do_req(2, 0, 0, 0, 0);            // R6 write-back of 0x11
        do_req(2, 2, 0, 0, 0);            // R6 evict Invalid
        do_req(1, 3, 8'h42, 0, 0);        // R3 store miss
        snoop(4, 3);                      // R8 write-back no effect
        snoop(5, 3);                      // R8 reply no effect
        do_req(0, 3, 0, 0, 0);            // R5 still Modified, 0x42
        snoop(2, 3);                      // R8 owner supplies, Invalid
        do_req(0, 2, 0, 0, 0);            // R2 Exclusive
        snoop(3, 2);                      // R8 invalidate
        do_req(0, 2, 0, 0, 1);            // R2 miss again, Shared
        do_req(2, 2, 0, 0, 0);            // R6 silent evict
        // R10: snoop and hit on another frame in the same cycle
        do_req(1, 0, 8'h21, 0, 0);
        req_valid = 1; req_op = 2'd0; req_frame = 0;
        snp_valid = 1; snp_cmd = 3'd1; snp_frame = 1;
        step();
        chk("R10", "other frame proceeds", last_ready, 1);
        snp_frame = 0;
        step();
        chk("R10", "same frame stalls", last_ready, 0);
        snp_valid = 0;
        step();
        req_valid = 0;
        // Random mix
        for (int n = 0; n < 4000; n++) begin
            if (!req_valid || last_ready) begin
                if ($urandom % 3 != 0) begin
                    req_valid = 1; req_op = 2'($urandom % 3);
                    req_frame = FW'($urandom); req_wdata = DW'($urandom);
                end else req_valid = 0;
            end
            bus_gnt = 1'($urandom % 2);
            fill_valid = ($urandom % 3 != 0);
            fill_data = DW'($urandom);
            fill_shared = 1'($urandom % 2);
            snp_valid = ($urandom % 4 == 0);
            snp_cmd = 3'(1 + $urandom % 5);
            snp_frame = FW'($urandom);
            step();
        end
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule